// File: doc/BRIEF.md
# Transmit FIFO with Space Request and Mid-Frame Abort

This block sits between a host bus and a byte serializer in a 10 Mb/s Ethernet-style MAC. The host pushes 16-bit words into a byte-wide queue. The low byte of each word leaves first, then the high byte. The serializer pulls one byte at a time. An active-low request output tells the host that there is room for a programmed burst of word writes. The burst size is set by a two-bit watermark code. A burst-mode bit is held in the configuration but leaves the request rule unchanged.

When the host clears the transmit enable while a frame is partly sent, the block does not simply stop. The serializer gets one more byte, marked as the end of the frame and flagged so that the CRC is corrupted. The queue is then emptied. The request stays off until transmit is enabled again. A hardware reset and a software reset both clear the configuration and the queue.

Top module: `tx_fifo_ctrl`

## Requirements
- R1: After hardware reset, `tx_req_n` is 1 and `ser_valid` is 0, and the enable, burst and watermark fields are all zero.
- R2: A `soft_rst` pulse clears the enable, burst and watermark fields and empties the queue. Afterwards `tx_req_n` is 1, and once transmit is enabled again `ser_valid` stays 0.
- R3: `tx_req_n` is 0 exactly when transmit is enabled, no abort is pending, and free bytes (DEPTH minus stored bytes) are at least the threshold for the watermark code. The codes map as follows: 0 selects WM_LO, 1 selects WM_MID, 2 selects WM_HI, and the reserved code 3 selects WM_LO.
- R4: The burst-mode bit has no effect on `tx_req_n`.
- R5: While transmit is disabled and no abort is pending, `ser_valid` is 0, so no transmission starts.
- R6: Bytes leave in write order, low byte before high byte. `ser_last` is 1 only on the high byte of a word written with `host_last` set.
- R7: Clearing the enable while a frame is in progress starts an abort. The serializer is shown one final byte with `ser_valid` and `ser_last` at 1. `ser_crc_bad` pulses for the single cycle in which that byte is popped. After that pop the queue is empty.
- R8: From the start of an abort, `tx_req_n` stays 1 until the enable is written to 1 again. On an empty queue it then drops to 0.
- R9: Clearing the enable with no frame in progress empties the queue at once, and no `ser_crc_bad` pulse is produced.
- R10: A host write is ignored when transmit is disabled, when an abort is pending, or when fewer than 2 bytes are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous software reset |
| cfg_we | input | 1 | Loads the three configuration fields |
| cfg_tx_en | input | 1 | Transmit enable value |
| cfg_burst | input | 1 | Burst-mode value |
| cfg_wm | input | 2 | Watermark code |
| host_wr | input | 1 | Host word write strobe |
| host_data | input | 16 | Write data; the low byte is sent first |
| host_last | input | 1 | The word ends a frame |
| ser_pop | input | 1 | Serializer takes the presented byte |
| ser_valid | output | 1 | A byte is presented |
| ser_data | output | 8 | Presented byte |
| ser_last | output | 1 | Presented byte ends the frame |
| ser_crc_bad | output | 1 | The CRC of the popped final byte must be corrupted |
| tx_req_n | output | 1 | Space request, active low |

## Verification
The bench builds the block with DEPTH=16 and thresholds of 4, 8 and 12 bytes. A few word writes therefore reach each threshold edge exactly, fill the queue completely, and try one write beyond full. The small depth also keeps a mid-frame abort short, so it can be followed byte by byte, including the flush and the re-enable that comes after it.

// File: rtl/tx_fifo_ctrl.sv
`timescale 1ns/1ps
module tx_fifo_ctrl #(
  parameter int DEPTH  = 64,
  parameter int WM_LO  = 8,
  parameter int WM_MID = 16,
  parameter int WM_HI  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        cfg_we,
  input  logic        cfg_tx_en,
  input  logic        cfg_burst,
  input  logic [1:0]  cfg_wm,
  input  logic        host_wr,
  input  logic [15:0] host_data,
  input  logic        host_last,
  input  logic        ser_pop,
  output logic        ser_valid,
  output logic [7:0]  ser_data,
  output logic        ser_last,
  output logic        ser_crc_bad,
  output logic        tx_req_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [8:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, need;
  logic          en_q, burst_q, in_frame, abort_q;
  logic [1:0]    wm_q;

  wire [CW-1:0] free     = CW'(DEPTH) - cnt;
  wire          has_data = (cnt != '0);
  wire          head_lst = has_data && mem[rp][8];

  always_comb begin
    case (wm_q)
      2'd1:    need = CW'(WM_MID);
      2'd2:    need = CW'(WM_HI);
      default: need = CW'(WM_LO);
    endcase
  end

  assign ser_valid   = abort_q || (en_q && has_data);
  assign ser_data    = has_data ? mem[rp][7:0] : 8'h00;
  assign ser_last    = abort_q || head_lst;
  assign ser_crc_bad = ser_pop && abort_q;
  assign tx_req_n    = !(en_q && !abort_q && free >= need);

  wire pop_ok     = ser_pop && ser_valid;
  wire wr_ok      = host_wr && en_q && !abort_q && free >= CW'(2);
  wire drop_en    = cfg_we && !cfg_tx_en && en_q;
  wire frame_live = in_frame && !(pop_ok && head_lst);
  wire abort_go   = drop_en && frame_live && !abort_q;
  wire flush      = soft_rst || (pop_ok && abort_q) || (drop_en && !frame_live && !abort_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; burst_q <= 1'b0; wm_q <= 2'd0;
    end else if (soft_rst) begin
      en_q <= 1'b0; burst_q <= 1'b0; wm_q <= 2'd0;
    end else if (cfg_we) begin
      en_q <= cfg_tx_en; burst_q <= cfg_burst; wm_q <= cfg_wm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; wp <= '0; rp <= '0; in_frame <= 1'b0; abort_q <= 1'b0;
    end else if (flush) begin
      cnt <= '0; wp <= '0; rp <= '0; in_frame <= 1'b0; abort_q <= 1'b0;
    end else begin
      cnt <= cnt + (wr_ok ? CW'(2) : CW'(0)) - (pop_ok ? CW'(1) : CW'(0));
      if (wr_ok)  wp <= wp + AW'(2);
      if (pop_ok) begin
        rp       <= rp + AW'(1);
        in_frame <= !head_lst;
      end
      if (abort_go) abort_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      mem[wp]         <= {1'b0, host_data[7:0]};
      mem[wp + AW'(1)] <= {host_last, host_data[15:8]};
    end
  end

  AST_REQ_DROPS_WITH_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> tx_req_n); // R8
  AST_CRC_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    ser_crc_bad |-> (ser_last && ser_valid)); // R7
  AST_EMPTY_AFTER_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_crc_bad && !soft_rst) |=> (cnt == '0 && !ser_valid)); // R7
  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !abort_q) |-> !ser_valid); // R5
  AST_REQ_HAS_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_req_n |-> (free >= CW'(WM_LO) || free >= CW'(WM_MID) || free >= CW'(WM_HI))); // R3
  AST_BURST_NEUTRAL: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(burst_q) && $stable(cnt) && $stable(wm_q) && $stable(en_q) && $stable(abort_q)) |-> $stable(tx_req_n)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && free < CW'(2) && !flush && !pop_ok) |=> $stable(cnt)); // R10
endmodule

// File: tb/tb_tx_fifo_ctrl.sv
`timescale 1ns/1ps
module tb_tx_fifo_ctrl;
  logic clk = 0, rst_n = 0, soft_rst = 0, cfg_we = 0, cfg_tx_en = 0, cfg_burst = 0;
  logic [1:0] cfg_wm = 0;
  logic host_wr = 0, host_last = 0, ser_pop = 0;
  logic [15:0] host_data = 0;
  logic ser_valid, ser_last, ser_crc_bad, tx_req_n;
  logic [7:0] ser_data;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  tx_fifo_ctrl #(.DEPTH(16), .WM_LO(4), .WM_MID(8), .WM_HI(12)) dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin n_bad++; $display("FAIL %s: actual %0h expected %0h", tag, act, exp); end
  endtask

  task automatic hw_reset();
    rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
  endtask

  task automatic cfg(input bit en, input bit bu, input logic [1:0] wm);
    cfg_we = 1; cfg_tx_en = en; cfg_burst = bu; cfg_wm = wm;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic wr(input logic [15:0] d, input bit lst);
    host_wr = 1; host_data = d; host_last = lst;
    @(negedge clk); host_wr = 0; host_last = 0;
  endtask

  task automatic pop(input logic [7:0] d, input bit lst, input bit crc, input string tag);
    chk(ser_valid === 1'b1, {tag, " valid"}, ser_valid, 1);
    chk(ser_data === d, {tag, " data"}, ser_data, d);
    chk(ser_last === lst, {tag, " last"}, ser_last, lst);
    ser_pop = 1; #1;
    chk(ser_crc_bad === crc, {tag, " crc"}, ser_crc_bad, crc);
    @(negedge clk); ser_pop = 0;
  endtask

  task automatic t_reset();
    hw_reset();
    chk(tx_req_n === 1'b1, "R1 req after reset", tx_req_n, 1);
    chk(ser_valid === 1'b0, "R1 valid after reset", ser_valid, 0);
  endtask

  task automatic t_threshold();
    hw_reset();
    cfg(1, 0, 2);
    chk(tx_req_n === 1'b0, "R3 empty wm2", tx_req_n, 0);
    for (int i = 0; i < 2; i++) wr({8'(8'h11 + 2*i), 8'(8'h10 + 2*i)}, 0);
    chk(tx_req_n === 1'b0, "R3 free12 wm2", tx_req_n, 0);
    wr(16'h1514, 0);
    chk(tx_req_n === 1'b1, "R3 free10 wm2", tx_req_n, 1);
    cfg(1, 0, 1);
    chk(tx_req_n === 1'b0, "R3 free10 wm1", tx_req_n, 0);
    cfg(1, 0, 3);
    chk(tx_req_n === 1'b0, "R3 free10 wm3", tx_req_n, 0);
    cfg(1, 1, 3);
    chk(tx_req_n === 1'b0, "R4 burst set", tx_req_n, 0);
    for (int i = 3; i < 6; i++) wr({8'(8'h11 + 2*i), 8'(8'h10 + 2*i)}, 0);
    chk(tx_req_n === 1'b0, "R3 free4 wm3", tx_req_n, 0);
    wr(16'h1d1c, 0);
    chk(tx_req_n === 1'b1, "R3 free2 wm3", tx_req_n, 1);
    cfg(1, 0, 3);
    chk(tx_req_n === 1'b1, "R4 burst clear", tx_req_n, 1);
    wr(16'h1f1e, 1);
    wr(16'hEEEE, 1);
    for (int i = 0; i < 16; i++) pop(8'(8'h10 + i), i == 15, 0, "R6/R10 order");
    chk(ser_valid === 1'b0, "R10 write beyond full dropped", ser_valid, 0);
  endtask

  task automatic t_disabled();
    hw_reset();
    wr(16'h2120, 1);
    chk(ser_valid === 1'b0, "R5 disabled no start", ser_valid, 0);
    ser_pop = 1; @(negedge clk); ser_pop = 0;
    cfg(1, 0, 0);
    chk(ser_valid === 1'b0, "R10 write while disabled", ser_valid, 0);
    chk(tx_req_n === 1'b0, "R3 enabled empty", tx_req_n, 0);
    wr(16'h2322, 0);
    cfg(0, 0, 0);
    chk(ser_crc_bad === 1'b0, "R9 no crc pulse", ser_crc_bad, 0);
    chk(ser_valid === 1'b0, "R5 disabled again", ser_valid, 0);
    cfg(1, 0, 0);
    chk(ser_valid === 1'b0, "R9 idle flush", ser_valid, 0);
  endtask

  task automatic t_abort();
    hw_reset();
    cfg(1, 0, 0);
    wr(16'hA1A0, 0); wr(16'hB1B0, 0); wr(16'hC1C0, 1);
    pop(8'hA0, 0, 0, "R6 abort pre");
    pop(8'hA1, 0, 0, "R6 abort pre");
    cfg(0, 0, 0);
    chk(tx_req_n === 1'b1, "R8 req off in abort", tx_req_n, 1);
    wr(16'hD1D0, 0);
    pop(8'hB0, 1, 1, "R7 abort byte");
    chk(ser_valid === 1'b0, "R7 flushed", ser_valid, 0);
    chk(tx_req_n === 1'b1, "R8 req off until enable", tx_req_n, 1);
    cfg(1, 0, 0);
    chk(tx_req_n === 1'b0, "R8 req back", tx_req_n, 0);
    chk(ser_valid === 1'b0, "R10 write during abort", ser_valid, 0);
  endtask

  task automatic t_swrst();
    hw_reset();
    cfg(1, 1, 2);
    wr(16'h3130, 1);
    soft_rst = 1; @(negedge clk); soft_rst = 0;
    chk(tx_req_n === 1'b1, "R2 req after swrst", tx_req_n, 1);
    chk(ser_valid === 1'b0, "R2 valid after swrst", ser_valid, 0);
    cfg(1, 0, 0);
    chk(ser_valid === 1'b0, "R2 flushed", ser_valid, 0);
    chk(tx_req_n === 1'b0, "R2 req reenabled", tx_req_n, 0);
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_threshold();
    t_disabled();
    t_abort();
    t_swrst();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule